// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter with Buffered Gap Setting

This block turns one PWM input into a complementary high-side/low-side pair and puts a programmable gap, during which both outputs are inactive, at every transition of the input. The side that is turning off drops on the clock edge that first sees the input edge. The side that is turning on is held back for a number of clock cycles taken from a working gap value.

The gap length is set through an 8-bit setting register on a simple write bus, and this register can always be read back. The value written does not always take effect at once. While the associated timer is halted, a write takes effect on the same clock edge. While the timer is running, a write is only held and marked pending. It is moved into the working value on the next compare-match pulse from either of two compare channels, so the gap cannot change in the middle of a PWM period. The run/halt status and the compare-match pulses come from the timer outside this block.

Top module: `dtg_dead_time`

## Requirements
- R1: `reg_rdata` always shows the last value written through `reg_we`/`reg_wdata`. This is the written value and not the working gap value.
- R2: A write while `cnt_run`=0 becomes the working gap on the same clock edge. Any input edge sampled from the next edge onward uses it, and nothing is left pending.
- R3: A write while `cnt_run`=1 leaves the working gap unchanged and marks an update as pending. The exception is a write in the same cycle as a compare match.
- R4: While an update is pending, a pulse on `cmp_match_a` or on `cmp_match_b` moves the held value into the working gap and clears the pending mark. If a compare match comes in the same cycle as a running write, the newly written value is loaded.
- R5: A compare match with no update pending leaves the working gap unchanged.
- R6: If an update is still pending when `cnt_run` drops to 0, it is moved into the working gap on the first halted clock edge.
- R7: The output that is turning off goes low on the clock edge that samples the input edge. `pwm_out_hi` is low on the edge after any cycle in which `pwm_in`=0, and `pwm_out_lo` is low on the edge after any cycle in which `pwm_in`=1.
- R8: With a working gap of D>0 sampled at an input edge, the output that is turning on goes high exactly D clock cycles after the output that is turning off went low.
- R9: A working gap of 0 adds no delay. On the clock edge that samples an input edge, `pwm_out_hi` takes the new input level and `pwm_out_lo` takes its complement.
- R10: If the input toggles again before the gap has run out, the count starts again from the full working gap, and both outputs stay low until it runs out.
- R11: `pwm_out_hi` and `pwm_out_lo` are never both high.
- R12: Under reset both outputs are low, the working gap is 0 and nothing is pending. After reset, the output that matches the level of `pwm_in` is driven on the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the gap setting register |
| reg_wdata | input | 8 | Write data for the gap setting |
| reg_rdata | output | 8 | Read-back of the last written gap setting |
| cnt_run | input | 1 | Timer status: 1 = counting, 0 = halted |
| cmp_match_a | input | 1 | Compare-match pulse, first channel |
| cmp_match_b | input | 1 | Compare-match pulse, second channel |
| pwm_in | input | 1 | Source PWM waveform |
| pwm_out_hi | output | 1 | High-side output, active when the input is 1 |
| pwm_out_lo | output | 1 | Low-side output, active when the input is 0 |

## Verification
The bench sweeps every gap value from 0 to 20, plus 255, through halted writes. For each one it measures the exact number of both-low cycles on rising and falling input edges. An off-by-one counter would show as a gap one cycle too long or too short, and a broken zero case would insert a one-cycle gap. Running writes are checked for effect before and after compare matches on each channel, for a match with nothing pending, for a match in the same cycle as a write, and for a halt while an update is pending. A design that loaded early would shorten the old gap, and one that lost the pending mark would never apply the new value. A retoggle in the middle of a gap checks that the count restarts rather than finishing early and opening a short pulse.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } pair_t;

  typedef enum logic [1:0] {
    LD_NONE   = 2'd0,
    LD_DIRECT = 2'd1,
    LD_SYNC   = 2'd2,
    LD_FLUSH  = 2'd3
  } load_src_e;
endpackage

// File: rtl/dtg_preset_buf.sv
module dtg_preset_buf #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [DT_W-1:0] wdata,
  input  logic            run,
  input  logic            match,
  output logic [DT_W-1:0] hold_q,
  output logic [DT_W-1:0] work_q,
  output logic            pending_q
);
  import dtg_pkg::*;

  load_src_e src;

  // Pick the source of the working value for this cycle.
  always_comb begin
    src = LD_NONE;
    if (we && (!run || match))        src = LD_DIRECT;
    else if (!we && pending_q && match) src = LD_SYNC;
    else if (!we && pending_q && !run)  src = LD_FLUSH;
  end

  // The setting register has no reset: its content is whatever was last written.
  always_ff @(posedge clk) begin
    if (we) hold_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q    <= '0;
      pending_q <= 1'b0;
    end else begin
      unique case (src)
        LD_DIRECT: begin
          work_q    <= wdata;
          pending_q <= 1'b0;
        end
        LD_SYNC, LD_FLUSH: begin
          work_q    <= hold_q;
          pending_q <= 1'b0;
        end
        default: begin
          if (we) pending_q <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dtg_gap_engine.sv
module dtg_gap_engine #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic [DT_W-1:0] gap,
  output dtg_pkg::pair_t  outs_q
);
  import dtg_pkg::*;

  logic            prev_q;
  logic            busy_q;
  logic [DT_W-1:0] cnt_q;
  logic            edge_seen;
  pair_t           level_pair;

  assign edge_seen  = (pwm_in != prev_q);
  assign level_pair = '{hi: pwm_in, lo: ~pwm_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      outs_q <= '{hi: 1'b0, lo: 1'b0};
    end else begin
      prev_q <= pwm_in;
      if (edge_seen) begin
        if (gap == '0) begin
          busy_q <= 1'b0;
          outs_q <= level_pair;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= gap - 1'b1;
          outs_q <= '{hi: 1'b0, lo: 1'b0};
        end
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          outs_q <= level_pair;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        outs_q <= level_pair;
      end
    end
  end
endmodule

// File: rtl/dtg_dead_time.sv
module dtg_dead_time #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [DT_W-1:0] reg_wdata,
  output logic [DT_W-1:0] reg_rdata,
  input  logic            cnt_run,
  input  logic            cmp_match_a,
  input  logic            cmp_match_b,
  input  logic            pwm_in,
  output logic            pwm_out_hi,
  output logic            pwm_out_lo
);
  import dtg_pkg::*;

  logic [DT_W-1:0] dt_work;
  logic            upd_pending;
  pair_t           outs;

  dtg_preset_buf #(.DT_W(DT_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .wdata     (reg_wdata),
    .run       (cnt_run),
    .match     (cmp_match_a | cmp_match_b),
    .hold_q    (reg_rdata),
    .work_q    (dt_work),
    .pending_q (upd_pending)
  );

  dtg_gap_engine #(.DT_W(DT_W)) u_gap (
    .clk    (clk),
    .rst    (rst),
    .pwm_in (pwm_in),
    .gap    (dt_work),
    .outs_q (outs)
  );

  assign pwm_out_hi = outs.hi;
  assign pwm_out_lo = outs.lo;
endmodule

// File: rtl/dtg_dead_time_chk.sv
module dtg_dead_time_chk #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_we,
  input logic [DT_W-1:0] reg_wdata,
  input logic [DT_W-1:0] reg_rdata,
  input logic            cnt_run,
  input logic            cmp_match_a,
  input logic            cmp_match_b,
  input logic            pwm_in,
  input logic            pwm_out_hi,
  input logic            pwm_out_lo,
  input logic [DT_W-1:0] dt_work,
  input logic            upd_pending
);
  assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_rdata == $past(reg_wdata)));

  assert_halted_load_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !cnt_run) |=> (dt_work == $past(reg_wdata) && !upd_pending));

  assert_running_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_run && !cmp_match_a && !cmp_match_b) |=> $stable(dt_work));

  assert_match_clears_R4: assert property (@(posedge clk) disable iff (rst)
    ((cmp_match_a || cmp_match_b) && !reg_we) |=> !upd_pending);

  assert_hi_off_R7: assert property (@(posedge clk) disable iff (rst)
    !pwm_in |=> !pwm_out_hi);

  assert_lo_off_R7: assert property (@(posedge clk) disable iff (rst)
    pwm_in |=> !pwm_out_lo);

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(pwm_out_hi && pwm_out_lo));
endmodule

bind dtg_dead_time dtg_dead_time_chk #(.DT_W(DT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .cnt_run     (cnt_run),
  .cmp_match_a (cmp_match_a),
  .cmp_match_b (cmp_match_b),
  .pwm_in      (pwm_in),
  .pwm_out_hi  (pwm_out_hi),
  .pwm_out_lo  (pwm_out_lo),
  .dt_work     (dt_work),
  .upd_pending (upd_pending)
);

// File: tb/dtg_dead_time_bench.sv
module dtg_dead_time_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_run = 1'b0;
  logic       cmp_match_a = 1'b0;
  logic       cmp_match_b = 1'b0;
  logic       pwm_in = 1'b0;
  logic       pwm_out_hi, pwm_out_lo;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtg_dead_time u_dtg_dead_time (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_run(cnt_run), .cmp_match_a(cmp_match_a),
    .cmp_match_b(cmp_match_b), .pwm_in(pwm_in),
    .pwm_out_hi(pwm_out_hi), .pwm_out_lo(pwm_out_lo));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R11 monitor on every sample point
  always @(negedge clk) begin
    if (!rst && pwm_out_hi && pwm_out_lo) begin
      bad++;
      total++;
      $display("FAIL R11 actual=both_high expected=not_both");
    end
  end

  task automatic write_reg(input logic [7:0] v, input bit with_match);
    reg_we = 1'b1; reg_wdata = v; cmp_match_a = with_match;
    @(negedge clk);
    reg_we = 1'b0; cmp_match_a = 1'b0;
  endtask

  task automatic pulse_match(input bit chan_b);
    if (chan_b) cmp_match_b = 1'b1; else cmp_match_a = 1'b1;
    @(negedge clk);
    cmp_match_a = 1'b0; cmp_match_b = 1'b0;
  endtask

  // Toggle the input, then count samples until the turning-on output rises.
  // The expected count is gap+1 (the first sample follows the sampling edge).
  task automatic toggle_measure(input int gap, input string req);
    int n = 0;
    bit off_ok = 1'b1;
    bit on_lvl;
    pwm_in = ~pwm_in;
    on_lvl = pwm_in;
    while (n < 400) begin
      @(negedge clk);
      n++;
      if (n == 1) off_ok = on_lvl ? !pwm_out_lo : !pwm_out_hi;
      if ((on_lvl ? pwm_out_hi : pwm_out_lo) == 1'b1) break;
    end
    check(off_ok, "R7 off side dropped at once", off_ok, 1);
    check(n == gap + 1, req, n - 1, gap);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!pwm_out_hi && !pwm_out_lo, "R12 outputs low in reset", {pwm_out_hi, pwm_out_lo}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_out_lo && !pwm_out_hi, "R12 level side driven after reset", {pwm_out_hi, pwm_out_lo}, 1);
    // R12 working gap is 0 after reset, so R9 no-gap behaviour applies
    toggle_measure(0, "R9 zero gap after reset");

    // Halted sweep: R2 immediate load, R8 gap length, R9 zero, R1 read-back
    for (int d = 0; d <= 21; d++) begin
      int v = (d == 21) ? 255 : d;
      write_reg(v[7:0], 1'b0);
      check(reg_rdata == v[7:0], "R1 read-back", reg_rdata, v);
      toggle_measure(v, v == 0 ? "R9 zero gap" : "R2/R8 gap length");
      toggle_measure(v, v == 0 ? "R9 zero gap" : "R2/R8 gap length");
    end

    // R3 running write does not take effect yet
    write_reg(8'd5, 1'b0);
    cnt_run = 1'b1;
    @(negedge clk);
    write_reg(8'd12, 1'b0);
    check(reg_rdata == 8'd12, "R1 read-back while running", reg_rdata, 12);
    toggle_measure(5, "R3 old gap kept while running");
    // R4 channel a transfers pending value
    pulse_match(1'b0);
    toggle_measure(12, "R4 loaded on match a");
    // R5 match with nothing pending leaves gap alone
    pulse_match(1'b1);
    toggle_measure(12, "R5 no pending, gap kept");
    // R4 channel b
    write_reg(8'd3, 1'b0);
    toggle_measure(12, "R3 old gap kept");
    pulse_match(1'b1);
    toggle_measure(3, "R4 loaded on match b");
    // R4 coincident write and match loads the new value
    write_reg(8'd9, 1'b1);
    toggle_measure(9, "R4 coincident write and match");
    // R6 halting flushes pending value
    write_reg(8'd7, 1'b0);
    toggle_measure(9, "R3 old gap kept");
    cnt_run = 1'b0;
    @(negedge clk);
    toggle_measure(7, "R6 flushed on halt");

    // R10 retoggle inside the gap restarts the count
    write_reg(8'd10, 1'b0);
    pwm_in = ~pwm_in;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!pwm_out_hi && !pwm_out_lo, "R10 both low during gap", {pwm_out_hi, pwm_out_lo}, 0);
    end
    toggle_measure(10, "R10 restarted count");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule